// File: doc/BRIEF.md
# DMA Descriptor-Driven Address Sequencer

This block produces the read and write address stream of a single DMA channel from a transfer descriptor loaded over a parallel port. The descriptor carries two start addresses and two signed per-beat offsets. It also carries separate read and write beat sizes, a modulo width for each side, the byte count of one minor loop, a major iteration count, and two signed adjustments applied when a major loop finishes. Each service request runs one minor loop. The beats of that loop leave through a valid/ready port toward a simple memory port, with the read and write address of each beat side by side.

A modulo width M above zero locks every address bit from M upward, so only the low M bits take part in the offset addition. With M=5, a base of 0x2008 and an offset of 16, the write address flips between 0x2008 and 0x2018. This lets a two-register peripheral pair be refreshed from a table. Each minor loop lowers the current iteration count. When the count reaches zero, the signed end adjustments are added to both addresses, the count is reloaded from the beginning count, and a one-cycle done pulse is issued. A source adjustment equal to minus the table length therefore rewinds the read pointer to the table start.

Top module: `dma_addr_seq`

## Requirements
- R1: After synchronous reset, `beat_valid`, `major_done` and `cfg_err` are all 0.
- R2: A service request produces exactly N = nbytes / 2^S accepted beats, where S is the larger of the read and write size codes. Size code 0 is 8-bit, 1 is 16-bit and 2 is 32-bit. `beat_valid` goes high in the cycle after the request and goes low in the cycle after the N-th acceptance.
- R3: Each accepted beat adds the sign-extended read offset to the read address. A read modulo width of 0 disables wrapping.
- R4: With a modulo width M between 1 and 31, each accepted beat leaves address bits M and above unchanged and replaces the low M bits with the low M bits of address plus offset. This holds on both sides; M=0 gives a plain addition.
- R5: While `beat_valid` is high and `beat_ready` is low, both addresses and `beat_valid` hold. Addresses advance only on an accepted beat.
- R6: Each completed minor loop lowers the current iteration count by one. On the minor loop that brings it to zero, the signed last adjustments are added to the post-beat addresses without modulo, and the count reloads from the beginning count. A zero adjustment leaves the address as the beat left it.
- R7: `major_done` is high for exactly one cycle: the cycle after the final beat of a major loop is accepted. `beat_valid` is low in that cycle.
- R8: `cfg_err` is set by a load when any of these hold: nbytes is zero, nbytes is not a multiple of 2^S, either size code is 3, or the beginning count is zero. While it is set, requests produce no beats. A valid load clears it.
- R9: A request is ignored while a minor loop is in progress and before the first descriptor load.
- R10: `beat_rsize` and `beat_wsize` present the loaded read and write size codes during every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_load | input | 1 | Capture the descriptor fields, abandon any running loop |
| desc_saddr | input | AW | Read start address |
| desc_daddr | input | AW | Write start address |
| desc_soff | input | OW | Signed read offset per beat |
| desc_doff | input | OW | Signed write offset per beat |
| desc_ssize | input | 2 | Read size code |
| desc_dsize | input | 2 | Write size code |
| desc_smod | input | MW | Read modulo width (0 = off) |
| desc_dmod | input | MW | Write modulo width (0 = off) |
| desc_nbytes | input | NW | Bytes per minor loop |
| desc_biter | input | IW | Beginning major iteration count |
| desc_slast | input | AW | Signed read adjustment at major end |
| desc_dlast | input | AW | Signed write adjustment at major end |
| svc_req | input | 1 | Service request, starts one minor loop |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat accepted when high with beat_valid |
| beat_raddr | output | AW | Read address of the offered beat |
| beat_waddr | output | AW | Write address of the offered beat |
| beat_rsize | output | 2 | Read size code of the beat |
| beat_wsize | output | 2 | Write size code of the beat |
| major_done | output | 1 | One-cycle pulse at major loop completion |
| cfg_err | output | 1 | Loaded descriptor is unusable |

## Verification
A wrong beat counter shows up as `beat_valid` staying high past the N-th acceptance, or dropping early, within the same minor loop. A wrong iteration count moves the `major_done` pulse to the wrong request, and the missing or misplaced rewind makes the next request's first read address wrong on the cycle it becomes valid. Modulo or offset faults appear on the very next offered beat as a wrong address bit. The bench compares every offered address against an arithmetic model across size codes, modulo widths and backpressure patterns.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // Larger of two size codes: the beat granule in bytes is 2**code.
  function automatic logic [1:0] wider_size(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned SIDES = 2;   // 0 = read side, 1 = write side
  localparam logic [1:0]  MAX_SZ = 2'd2;

endpackage

// File: rtl/dma_seq_cfg_check.sv
module dma_seq_cfg_check
  import dma_seq_pkg::*;
#(
  parameter int NW = 16,
  parameter int IW = 9
) (
  input  logic [1:0]    ssize,
  input  logic [1:0]    dsize,
  input  logic [NW-1:0] nbytes,
  input  logic [IW-1:0] biter,
  output logic [NW-1:0] nbeats,
  output logic          bad
);
  logic [1:0]    gran;
  logic [NW-1:0] low_mask;

  always_comb begin
    gran     = wider_size(ssize, dsize);
    low_mask = (NW'(1) << gran) - NW'(1);
    nbeats   = nbytes >> gran;
    bad      = (ssize > MAX_SZ) || (dsize > MAX_SZ) ||
               (nbytes == '0) || ((nbytes & low_mask) != '0) ||
               (biter == '0);
  end
endmodule

// File: rtl/dma_seq_addr_step.sv
module dma_seq_addr_step #(
  parameter int AW = 32,
  parameter int MW = 5
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] delta,
  input  logic [MW-1:0] modw,
  output logic [AW-1:0] next
);
  logic [AW-1:0] sum;
  logic [AW-1:0] frozen;

  always_comb begin
    sum    = base + delta;
    frozen = (modw == '0) ? '0 : ~((AW'(1) << modw) - AW'(1));
    next   = (base & frozen) | (sum & ~frozen);
  end
endmodule

// File: rtl/dma_seq_loop_ctrl.sv
module dma_seq_loop_ctrl #(
  parameter int NW = 16,
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] load_biter,
  input  logic          blocked,
  input  logic [NW-1:0] nbeats,
  input  logic [IW-1:0] biter,
  input  logic          req,
  input  logic          beat_ready,
  output logic          beat_valid,
  output logic          fire,
  output logic          minor_end,
  output logic          major_end,
  output logic          major_done
);
  logic [NW-1:0] left_q;
  logic [IW-1:0] citer_q;

  assign fire      = beat_valid & beat_ready;
  assign minor_end = fire && (left_q == NW'(1));
  assign major_end = minor_end && (citer_q == IW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      left_q     <= '0;
      citer_q    <= '0;
      major_done <= 1'b0;
    end else begin
      major_done <= 1'b0;
      if (load) begin
        beat_valid <= 1'b0;
        left_q     <= '0;
        citer_q    <= load_biter;
      end else if (!beat_valid) begin
        if (req && !blocked) begin
          beat_valid <= 1'b1;
          left_q     <= nbeats;
        end
      end else if (fire) begin
        left_q <= left_q - NW'(1);
        if (minor_end) begin
          beat_valid <= 1'b0;
          if (major_end) begin
            citer_q    <= biter;
            major_done <= 1'b1;
          end else begin
            citer_q <= citer_q - IW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int MW = 5,
  parameter int NW = 16,
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          desc_load,
  input  logic [AW-1:0] desc_saddr,
  input  logic [AW-1:0] desc_daddr,
  input  logic [OW-1:0] desc_soff,
  input  logic [OW-1:0] desc_doff,
  input  logic [1:0]    desc_ssize,
  input  logic [1:0]    desc_dsize,
  input  logic [MW-1:0] desc_smod,
  input  logic [MW-1:0] desc_dmod,
  input  logic [NW-1:0] desc_nbytes,
  input  logic [IW-1:0] desc_biter,
  input  logic [AW-1:0] desc_slast,
  input  logic [AW-1:0] desc_dlast,
  input  logic          svc_req,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] beat_raddr,
  output logic [AW-1:0] beat_waddr,
  output logic [1:0]    beat_rsize,
  output logic [1:0]    beat_wsize,
  output logic          major_done,
  output logic          cfg_err
);
  localparam int EXT = AW - OW;

  // Per-side descriptor state, index 0 = read, 1 = write
  logic [AW-1:0] addr_q [SIDES];
  logic [AW-1:0] off_q  [SIDES];
  logic [AW-1:0] last_q [SIDES];
  logic [MW-1:0] mod_q  [SIDES];
  logic [AW-1:0] step_n [SIDES];
  logic [AW-1:0] init_a [SIDES];
  logic [AW-1:0] init_o [SIDES];
  logic [AW-1:0] init_l [SIDES];
  logic [MW-1:0] init_m [SIDES];

  logic [1:0]    ssz_q, dsz_q;
  logic [NW-1:0] nbeats_q;
  logic [IW-1:0] biter_q;
  logic          err_q, loaded_q;

  logic [NW-1:0] chk_nbeats;
  logic          chk_bad;
  logic          fire, minor_end, major_end;

  assign init_a[0] = desc_saddr;
  assign init_a[1] = desc_daddr;
  assign init_o[0] = {{EXT{desc_soff[OW-1]}}, desc_soff};
  assign init_o[1] = {{EXT{desc_doff[OW-1]}}, desc_doff};
  assign init_l[0] = desc_slast;
  assign init_l[1] = desc_dlast;
  assign init_m[0] = desc_smod;
  assign init_m[1] = desc_dmod;

  dma_seq_cfg_check #(.NW(NW), .IW(IW)) u_cfg (
    .ssize  (desc_ssize),
    .dsize  (desc_dsize),
    .nbytes (desc_nbytes),
    .biter  (desc_biter),
    .nbeats (chk_nbeats),
    .bad    (chk_bad)
  );

  dma_seq_loop_ctrl #(.NW(NW), .IW(IW)) u_loop (
    .clk        (clk),
    .rst        (rst),
    .load       (desc_load),
    .load_biter (desc_biter),
    .blocked    (err_q | ~loaded_q),
    .nbeats     (nbeats_q),
    .biter      (biter_q),
    .req        (svc_req),
    .beat_ready (beat_ready),
    .beat_valid (beat_valid),
    .fire       (fire),
    .minor_end  (minor_end),
    .major_end  (major_end),
    .major_done (major_done)
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dma_seq_addr_step #(.AW(AW), .MW(MW)) u_step (
      .base  (addr_q[g]),
      .delta (off_q[g]),
      .modw  (mod_q[g]),
      .next  (step_n[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[g] <= '0;
        off_q[g]  <= '0;
        last_q[g] <= '0;
        mod_q[g]  <= '0;
      end else if (desc_load) begin
        addr_q[g] <= init_a[g];
        off_q[g]  <= init_o[g];
        last_q[g] <= init_l[g];
        mod_q[g]  <= init_m[g];
      end else if (fire) begin
        addr_q[g] <= major_end ? (step_n[g] + last_q[g]) : step_n[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ssz_q    <= '0;
      dsz_q    <= '0;
      nbeats_q <= '0;
      biter_q  <= '0;
      err_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else if (desc_load) begin
      ssz_q    <= desc_ssize;
      dsz_q    <= desc_dsize;
      nbeats_q <= chk_nbeats;
      biter_q  <= desc_biter;
      err_q    <= chk_bad;
      loaded_q <= 1'b1;
    end
  end

  assign beat_raddr = addr_q[0];
  assign beat_waddr = addr_q[1];
  assign beat_rsize = ssz_q;
  assign beat_wsize = dsz_q;
  assign cfg_err    = err_q;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          desc_load,
  input logic          svc_req,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] beat_raddr,
  input logic [AW-1:0] beat_waddr,
  input logic          major_done,
  input logic          cfg_err
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready && !desc_load) |=>
      (beat_valid && $stable(beat_raddr) && $stable(beat_waddr)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    major_done |=> !major_done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    major_done |-> !beat_valid);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !beat_valid);

  // R9
  start_by_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(beat_valid) |-> $past(svc_req));
endmodule

bind dma_addr_seq dma_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .desc_load  (desc_load),
  .svc_req    (svc_req),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_raddr (beat_raddr),
  .beat_waddr (beat_waddr),
  .major_done (major_done),
  .cfg_err    (cfg_err)
);

// File: tb/sim_dma_addr_seq.sv
`timescale 1ns/1ps
module sim_dma_addr_seq;
  localparam int AW = 32, OW = 16, MW = 5, NW = 16, IW = 9;

  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic          desc_load = 0, svc_req = 0, beat_ready = 0;
  logic [AW-1:0] desc_saddr = 0, desc_daddr = 0, desc_slast = 0, desc_dlast = 0;
  logic [OW-1:0] desc_soff = 0, desc_doff = 0;
  logic [1:0]    desc_ssize = 0, desc_dsize = 0;
  logic [MW-1:0] desc_smod = 0, desc_dmod = 0;
  logic [NW-1:0] desc_nbytes = 0;
  logic [IW-1:0] desc_biter = 0;
  logic          beat_valid, major_done, cfg_err;
  logic [AW-1:0] beat_raddr, beat_waddr;
  logic [1:0]    beat_rsize, beat_wsize;

  dma_addr_seq #(.AW(AW), .OW(OW), .MW(MW), .NW(NW), .IW(IW)) u0 (.*);

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  // model state
  logic [31:0] m_s, m_d, m_soff, m_doff, m_slast, m_dlast;
  int m_smod, m_dmod, m_iter, m_biter, m_nb;
  logic [31:0] first_s, first_d;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] madd(input logic [31:0] a, input logic [31:0] d, input int m);
    logic [31:0] low;
    if (m == 0) return a + d;
    low = (32'h1 << m) - 32'h1;
    return (a & ~low) | ((a + d) & low);
  endfunction

  task automatic load_desc(input logic [31:0] sa, input logic [31:0] da, input int so, input int dof,
                           input int ssz, input int dsz, input int sm, input int dm,
                           input int nbytes, input int biter, input int sl, input int dl);
    int g;
    @(negedge clk);
    desc_saddr = sa; desc_daddr = da; desc_soff = OW'(so); desc_doff = OW'(dof);
    desc_ssize = 2'(ssz); desc_dsize = 2'(dsz); desc_smod = MW'(sm); desc_dmod = MW'(dm);
    desc_nbytes = NW'(nbytes); desc_biter = IW'(biter); desc_slast = AW'(sl); desc_dlast = AW'(dl);
    desc_load = 1;
    @(negedge clk);
    desc_load = 0;
    g = (ssz > dsz) ? ssz : dsz;
    m_s = sa; m_d = da; m_soff = 32'(so); m_doff = 32'(dof); m_slast = 32'(sl); m_dlast = 32'(dl);
    m_smod = sm; m_dmod = dm; m_biter = biter; m_iter = biter; m_nb = nbytes >> g;
  endtask

  // one service request; bp selects pseudo-random backpressure
  task automatic run_req(input bit bp);
    int got = 0, cyc = 0;
    bit exp_major = 0;
    svc_req = 1;
    @(negedge clk);
    svc_req = 0;
    first_s = beat_raddr; first_d = beat_waddr;
    while (got < m_nb && cyc < 2000) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      beat_ready = bp ? lfsr[0] : 1'b1;
      if (!beat_valid) begin
        chk(0, "R2 valid dropped early", got, m_nb);
        break;
      end
      chk(beat_raddr == m_s, "R3 read addr", beat_raddr, m_s);
      chk(beat_waddr == m_d, "R4 write addr", beat_waddr, m_d);
      chk(beat_rsize == desc_ssize && beat_wsize == desc_dsize, "R10 sizes",
          {beat_rsize, beat_wsize}, {desc_ssize, desc_dsize});
      if (beat_ready) begin
        got++;
        m_s = madd(m_s, m_soff, m_smod);
        m_d = madd(m_d, m_doff, m_dmod);
        if (got == m_nb) begin
          m_iter--;
          if (m_iter == 0) begin
            m_s += m_slast; m_d += m_dlast; m_iter = m_biter; exp_major = 1;
          end
        end
      end
      @(negedge clk);
      cyc++;
    end
    beat_ready = 0;
    chk(!beat_valid, "R2 valid low after last beat", beat_valid, 0);
    chk(major_done == exp_major, "R7 major_done at loop end", major_done, exp_major);
    chk(beat_raddr == m_s && beat_waddr == m_d, "R6 post-loop addresses",
        {beat_raddr, beat_waddr}, {m_s, m_d});
    @(negedge clk);
    chk(!major_done, "R7 major_done one cycle", major_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(!beat_valid && !major_done && !cfg_err, "R1 reset state",
        {beat_valid, major_done, cfg_err}, 0);

    // R9: request before any load ignored
    svc_req = 1; @(negedge clk); svc_req = 0;
    repeat (2) @(negedge clk);
    chk(!beat_valid, "R9 request before load", beat_valid, 0);

    // Main case: two 16-bit beats, dst toggles in 32-byte window, 4-entry-pair table
    load_desc(32'h1000, 32'h2008, 2, 16, 1, 1, 0, 5, 4, 4, -16, 0);
    chk(!cfg_err, "R8 good descriptor", cfg_err, 0);
    for (int r = 0; r < 8; r++) begin
      run_req(r >= 4);
      chk(first_s == 32'h1000 + 32'(4 * (r % 4)), "R6 rewind to table start", first_s,
          32'h1000 + 32'(4 * (r % 4)));
      chk(first_d == 32'h2008, "R4 dst toggles 0x2008/0x2018", first_d, 32'h2008);
    end

    // R9: request during a running minor loop is ignored
    svc_req = 1; @(negedge clk); svc_req = 0;
    svc_req = 1; beat_ready = 0; @(negedge clk);
    svc_req = 1; @(negedge clk); svc_req = 0;
    beat_ready = 1; @(negedge clk); @(negedge clk);
    beat_ready = 0;
    chk(!beat_valid, "R9 extra request ignored", beat_valid, 0);
    repeat (3) @(negedge clk);
    chk(!beat_valid, "R9 no further beats", beat_valid, 0);

    // R5: long stall keeps addresses
    load_desc(32'h4000, 32'h5000, 4, 4, 2, 2, 0, 0, 8, 1, 0, 0);
    svc_req = 1; @(negedge clk); svc_req = 0;
    first_s = beat_raddr;
    repeat (5) @(negedge clk);
    chk(beat_valid && beat_raddr == first_s && beat_waddr == 32'h5000, "R5 stall hold",
        beat_raddr, first_s);
    m_s = 32'h4000; m_d = 32'h5000;
    run_req(1'b1);  // the held loop is drained by this (request ignored while busy)

    // Sweep: sizes x modulo widths, negative read offsets, nonzero dst adjust
    for (int sz = 0; sz < 3; sz++) begin
      for (int mi = 0; mi < 3; mi++) begin
        int mw, b;
        mw = (mi == 0) ? 0 : mi + 2;
        b = 1 << sz;
        load_desc(32'h8000_0030, 32'h0000_7F38, -b, 3 * b, sz, sz, mw, mw, 3 * b, 2, 6 * b, 32'h40);
        for (int r = 0; r < 4; r++) run_req(r[0]);
      end
    end

    // R2: mixed sizes, granule is the wider one (32-bit): 8 bytes -> 2 beats
    load_desc(32'h100, 32'h200, 1, 4, 0, 2, 0, 0, 8, 3, 0, 0);
    run_req(1'b0);

    // R8: configuration errors
    load_desc(32'h0, 32'h0, 4, 4, 2, 2, 0, 0, 6, 1, 0, 0);
    chk(cfg_err, "R8 nbytes not multiple", cfg_err, 1);
    svc_req = 1; @(negedge clk); svc_req = 0; repeat (3) @(negedge clk);
    chk(!beat_valid, "R8 no beats on error", beat_valid, 0);
    load_desc(32'h0, 32'h0, 2, 2, 1, 1, 0, 0, 0, 1, 0, 0);
    chk(cfg_err, "R8 nbytes zero", cfg_err, 1);
    load_desc(32'h0, 32'h0, 2, 2, 1, 1, 0, 0, 4, 0, 0, 0);
    chk(cfg_err, "R8 biter zero", cfg_err, 1);
    load_desc(32'h0, 32'h0, 2, 2, 3, 1, 0, 0, 8, 1, 0, 0);
    chk(cfg_err, "R8 size code 3", cfg_err, 1);
    load_desc(32'h10, 32'h20, 2, 2, 1, 1, 0, 0, 2, 1, 0, 0);
    chk(!cfg_err, "R8 cleared by valid load", cfg_err, 0);
    run_req(1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule